// File: doc/BRIEF.md
# Pipelined Carry-Select Final Adder

This block is the last stage of a carry-save reduction tree. It takes a pair of 24-bit vectors, one holding the partial sums and one holding the partial carries, and adds them into a single 24-bit binary result. The pair must already carry the correct weights: the block adds the carry vector as it is and does not shift it.

The operands are cut into 4-bit ripple-carry segments. A 4-bit segment is small enough that its top sum bit, which depends on eight operand bits, needs only a short logic depth. Every segment except the lowest one computes two candidate results, one for a carry-in of 0 and one for a carry-in of 1. A registered select chain then picks the right candidates over three pipeline stages. The first stage registers the candidates. The second stage resolves the carries through the lower half of the segments. The third stage resolves the upper half and registers the final sum.

A valid flag moves alongside the data, so a new operand pair can enter on every cycle. The result is the sum modulo 2^24, and the carry out of the top bit is dropped.

Top module: `csel_add_pipe`

## Requirements
- R1: When `out_valid` is high, `out_result` equals `(in_sum_vec + in_carry_vec) mod 2^24`, using the operands that were presented with `in_valid` high exactly three rising clock edges earlier.
- R2: `out_valid` is high on the cycle after the third rising edge that follows a cycle with `in_valid` high, and low on the matching cycle after a cycle with `in_valid` low. Gaps in the input show up as gaps in the output, in the same order.
- R3: Operand pairs presented on consecutive cycles all produce results on consecutive cycles, in the order they were presented. No input cycle is ever refused.
- R4: The carry out of bit 23 is dropped. For example, 0x800000 + 0x800000 gives 0x000000, and 0xFFFFFF + 0xFFFFFF gives 0xFFFFFE.
- R5: A carry that starts in the lowest 4-bit segment and travels through every higher segment (for example 0x7FFFFF + 0x000001 = 0x800000) gives the correct sum.
- R6: While `rst_n` is low, `out_valid` is low. Operands that were in flight when reset was asserted never produce a high `out_valid` afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with the clock |
| in_valid | input | 1 | Marks a valid operand pair on this cycle |
| in_sum_vec | input | 24 | Partial-sum vector from the carry-save tree |
| in_carry_vec | input | 24 | Partial-carry vector from the carry-save tree, already aligned |
| out_valid | output | 1 | Marks a valid result on this cycle |
| out_result | output | 24 | Binary sum modulo 2^24 |

## Verification
The hardest case to reach from the ports is a carry that starts in the lowest segment and has to pass through the select logic of both resolve stages. Random operands rarely set up that long chain. The stimulus therefore uses operand pairs whose upper bits are all ones in a 4-bit span, or across the whole word, with a single 1 added at the bottom. It also places those pairs back to back, next to pairs that produce no carry, so that a stale stage-2 carry would end up applied to the wrong operand. A reset asserted while three pairs are in flight checks that none of them comes out.

// File: rtl/csel_pkg.sv
package csel_pkg;
  parameter int unsigned CSEL_WIDTH_DEF = 24;
  parameter int unsigned CSEL_SEG_W_DEF = 4;
  parameter int unsigned CSEL_LATENCY   = 3;

  typedef struct packed {
    logic c0;
    logic c1;
  } carry_pair_t;
endpackage

// File: rtl/csel_rca_seg.sv
module csel_rca_seg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] c;

  always_comb begin
    c[0] = cin;
    for (int i = 0; i < W; i++) begin
      s[i]   = a[i] ^ b[i] ^ c[i];
      c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end
    cout = c[W];
  end
endmodule

// File: rtl/csel_cand_seg.sv
module csel_cand_seg #(
  parameter int unsigned W      = 4,
  parameter bit          LOWEST = 1'b0
) (
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  output logic [W-1:0]         s0,
  output logic [W-1:0]         s1,
  output csel_pkg::carry_pair_t co
);
  generate
    if (LOWEST) begin : g_single
      logic [W-1:0] s_only;
      logic         c_only;
      csel_rca_seg #(.W(W)) u_rca (.a(a), .b(b), .cin(1'b0), .s(s_only), .cout(c_only));
      assign s0    = s_only;
      assign s1    = s_only;
      assign co.c0 = c_only;
      assign co.c1 = c_only;
    end else begin : g_dual
      logic c_zero, c_one;
      csel_rca_seg #(.W(W)) u_rca0 (.a(a), .b(b), .cin(1'b0), .s(s0), .cout(c_zero));
      csel_rca_seg #(.W(W)) u_rca1 (.a(a), .b(b), .cin(1'b1), .s(s1), .cout(c_one));
      assign co.c0 = c_zero;
      assign co.c1 = c_one;
    end
  endgenerate
endmodule

// File: rtl/csel_resolve.sv
module csel_resolve #(
  parameter int unsigned W = 4,
  parameter int unsigned N = 3
) (
  input  logic                        cin,
  input  logic [N-1:0][W-1:0]         s0,
  input  logic [N-1:0][W-1:0]         s1,
  input  csel_pkg::carry_pair_t [N-1:0] co,
  output logic [N-1:0][W-1:0]         sum,
  output logic                        cout
);
  logic [N:0] c;

  always_comb begin
    c[0] = cin;
    for (int k = 0; k < N; k++) begin
      sum[k] = c[k] ? s1[k] : s0[k];
      c[k+1] = c[k] ? co[k].c1 : co[k].c0;
    end
    cout = c[N];
  end
endmodule

// File: rtl/csel_add_pipe.sv
module csel_add_pipe #(
  parameter int unsigned WIDTH = csel_pkg::CSEL_WIDTH_DEF,
  parameter int unsigned SEG_W = csel_pkg::CSEL_SEG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_sum_vec,
  input  logic [WIDTH-1:0] in_carry_vec,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_result
);
  import csel_pkg::*;

  localparam int unsigned NSEG = WIDTH / SEG_W;
  localparam int unsigned NLO  = NSEG / 2;
  localparam int unsigned NHI  = NSEG - NLO;

  // Stage 0 (combinational): candidate generation
  logic        [NSEG-1:0][SEG_W-1:0] cand_s0, cand_s1;
  carry_pair_t [NSEG-1:0]            cand_co;

  generate
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
      csel_cand_seg #(.W(SEG_W), .LOWEST(g == 0)) u_seg (
        .a (in_sum_vec  [g*SEG_W +: SEG_W]),
        .b (in_carry_vec[g*SEG_W +: SEG_W]),
        .s0(cand_s0[g]),
        .s1(cand_s1[g]),
        .co(cand_co[g])
      );
    end
  endgenerate

  // Stage 1 registers
  logic                              st1_valid, st1_valid_d;
  logic        [NSEG-1:0][SEG_W-1:0] st1_s0, st1_s1;
  carry_pair_t [NSEG-1:0]            st1_co;
  logic                              st1_load;

  // Stage 2 registers
  logic                             st2_valid, st2_valid_d;
  logic        [NLO-1:0][SEG_W-1:0] st2_lo_sum, lo_sum_d;
  logic                             st2_mid_c, mid_c_d;
  logic        [NHI-1:0][SEG_W-1:0] st2_hi_s0, st2_hi_s1;
  carry_pair_t [NHI-1:0]            st2_hi_co;
  logic                             st2_load;

  // Stage 3 registers
  logic                             st3_valid, st3_valid_d;
  logic        [NHI-1:0][SEG_W-1:0] hi_sum_d;
  logic                             hi_cout_unused;
  logic        [WIDTH-1:0]          st3_sum, st3_sum_d;
  logic                             st3_load;

  csel_resolve #(.W(SEG_W), .N(NLO)) u_res_lo (
    .cin (1'b0),
    .s0  (st1_s0[NLO-1:0]),
    .s1  (st1_s1[NLO-1:0]),
    .co  (st1_co[NLO-1:0]),
    .sum (lo_sum_d),
    .cout(mid_c_d)
  );

  csel_resolve #(.W(SEG_W), .N(NHI)) u_res_hi (
    .cin (st2_mid_c),
    .s0  (st2_hi_s0),
    .s1  (st2_hi_s1),
    .co  (st2_hi_co),
    .sum (hi_sum_d),
    .cout(hi_cout_unused)
  );

  // Next-state logic
  always_comb begin
    st1_valid_d = in_valid;
    st2_valid_d = st1_valid;
    st3_valid_d = st2_valid;
    st1_load    = in_valid;
    st2_load    = st1_valid;
    st3_load    = st2_valid;
    st3_sum_d   = {hi_sum_d, st2_lo_sum};
  end

  // Valid pipeline: cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_valid <= 1'b0;
      st2_valid <= 1'b0;
      st3_valid <= 1'b0;
    end else begin
      st1_valid <= st1_valid_d;
      st2_valid <= st2_valid_d;
      st3_valid <= st3_valid_d;
    end
  end

  // Data registers: no reset, loaded under valid
  always_ff @(posedge clk) begin
    if (st1_load) begin
      st1_s0 <= cand_s0;
      st1_s1 <= cand_s1;
      st1_co <= cand_co;
    end
  end

  always_ff @(posedge clk) begin
    if (st2_load) begin
      st2_lo_sum <= lo_sum_d;
      st2_mid_c  <= mid_c_d;
      st2_hi_s0  <= st1_s0[NSEG-1:NLO];
      st2_hi_s1  <= st1_s1[NSEG-1:NLO];
      st2_hi_co  <= st1_co[NSEG-1:NLO];
    end
  end

  always_ff @(posedge clk) begin
    if (st3_load) begin
      st3_sum <= st3_sum_d;
    end
  end

  assign out_valid  = st3_valid;
  assign out_result = st3_sum;
endmodule

// File: rtl/csel_add_pipe_chk.sv
module csel_add_pipe_chk #(
  parameter int unsigned WIDTH = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] in_sum_vec,
  input logic [WIDTH-1:0] in_carry_vec,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_result
);
  logic [2:0]       since_rst;
  logic [WIDTH-1:0] ref_sum;

  assign ref_sum = in_sum_vec + in_carry_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd3) |-> (out_valid == $past(in_valid, 3))); // R2

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd3 && out_valid) |-> (out_result == $past(ref_sum, 3))); // R1

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4 && $past(in_valid, 3) && $past(in_valid, 4)) |-> (out_valid && $past(out_valid))); // R3

  AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_result)); // R1

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!out_valid); // R6
    end
  end
endmodule

bind csel_add_pipe csel_add_pipe_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_sum_vec  (in_sum_vec),
  .in_carry_vec(in_carry_vec),
  .out_valid   (out_valid),
  .out_result  (out_result)
);

// File: tb/csel_add_pipe_tb.sv
module csel_add_pipe_tb;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_sum_vec, in_carry_vec;
  logic         out_valid;
  logic [W-1:0] out_result;

  typedef struct {
    logic [W-1:0] val;
    int           cyc;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  int    wdog = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  csel_add_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_sum_vec(in_sum_vec), .in_carry_vec(in_carry_vec),
    .out_valid(out_valid), .out_result(out_result)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Driver: call at a negedge; returns at the next negedge
  task automatic drive(input bit v, input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    exp_t e;
    in_valid     = v;
    in_sum_vec   = a;
    in_carry_vec = b;
    if (v) begin
      e.val = a + b;
      e.cyc = cyc;
      exp_q.push_back(e);
      tag_q.push_back(req);
    end
    @(negedge clk);
  endtask

  // Monitor: samples at negedge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected out_valid", {W{1'b0}}, {W{1'b0}});
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_result === e.val, t, "result", out_result, e.val);
        check((cyc - e.cyc) == 3, "R2", "latency", W'(cyc - e.cyc), W'(3));
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    wdog <= wdog + 1;
    if (wdog > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", wdog);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [W-1:0] lfsr;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sum_vec = '0; in_carry_vec = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R6", "out_valid in reset", W'(out_valid), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0, "R6", "out_valid after reset", W'(out_valid), '0);

    // R1 basic patterns with gaps (R2)
    drive(1, 24'h000000, 24'h000000, "R1");
    drive(0, 24'h0, 24'h0, "R2");
    drive(1, 24'h123456, 24'h010101, "R1");
    drive(0, 24'h0, 24'h0, "R2");
    drive(0, 24'h0, 24'h0, "R2");
    drive(1, 24'h00000F, 24'h000001, "R5");
    // R5 full-length carry chains, mixed with no-carry neighbours
    drive(1, 24'h7FFFFF, 24'h000001, "R5");
    drive(1, 24'h000000, 24'h000001, "R5");
    drive(1, 24'h0FFFFF, 24'h000001, "R5");
    drive(1, 24'hFFF0FF, 24'h000F01, "R5");
    // R4 wrap
    drive(1, 24'hFFFFFF, 24'h000001, "R4");
    drive(1, 24'h800000, 24'h800000, "R4");
    drive(1, 24'hFFFFFF, 24'hFFFFFF, "R4");
    repeat (6) drive(0, 24'h0, 24'h0, "R2");
    check(exp_q.size() == 0, "R2", "queue drained", W'(exp_q.size()), '0);

    // R3 back-to-back stream
    lfsr = 24'hACE1B5;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      drive(1, lfsr, {lfsr[11:0], lfsr[23:12]} ^ 24'h5A5A5A, "R3");
    end
    repeat (6) drive(0, 24'h0, 24'h0, "R3");
    check(exp_q.size() == 0, "R3", "stream drained", W'(exp_q.size()), '0);

    // R6 reset with items in flight
    drive(1, 24'h111111, 24'h222222, "R6");
    drive(1, 24'h333333, 24'h444444, "R6");
    drive(1, 24'h555555, 24'h666666, "R6");
    in_valid = 1'b0;
    rst_n = 1'b0;
    exp_q.delete();
    tag_q.delete();
    @(negedge clk);
    check(out_valid === 1'b0, "R6", "out_valid in mid reset", W'(out_valid), '0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R6", "no stale output", W'(out_valid), '0);
    end

    // after reset the pipe works again (R1)
    drive(1, 24'hABCDEF, 24'h123456, "R1");
    repeat (5) drive(0, 24'h0, 24'h0, "R1");
    check(exp_q.size() == 0, "R1", "post-reset drained", W'(exp_q.size()), '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule